// File: doc/BRIEF.md
# Link Status Register

This block keeps the 16-bit status word of a serial point-to-point link port. It does not train the link. The layers around it report what happens, and it turns those reports into register bits. Those reports are the training level (configuration or recovery), bandwidth-change strobes with an autonomy flag, retrain requests, the link-down level, the data-link-active level and the current link speed.

Two bits are sticky and are cleared by writing 1. One records changes of speed or width that were made autonomously. The other records changes made to recover from unreliable operation, and also records completed retrains that software asked for. Neither bit is set while the link is down. Two bits follow live state, one bit is fixed by a parameter, and the low nibble shows the current link speed. Reads are combinational in the cycle `rd_en` is high.

Top module: `link_status_reg`

## Requirements
- R1: After reset, with all event inputs idle, `link_speed` = 1 and `dl_active` = 0, the register reads 0x1001 with default parameters.
- R2: A `bw_chg` strobe with `bw_auto` = 1 while `link_down` = 0 sets bit 15 at the next clock edge. This covers autonomous local changes and far-end changes marked autonomous.
- R3: A `bw_chg` strobe with `bw_auto` = 0 while `link_down` = 0 sets bit 14 at the next clock edge. This covers reliability-driven changes and far-end changes not marked autonomous.
- R4: After a `retrain_req` pulse, the next exit of the training level (`train_cfg_rec` falling) sets bit 14. This holds even if training was already under way when the request arrived. A training exit without a pending request does not set bit 14.
- R5: While `link_down` = 1, bandwidth-change strobes set neither bit 15 nor bit 14, and any pending retrain request is discarded.
- R6: A write with data bit 15 (or 14) equal to 1 clears that bit. A written 0 leaves it unchanged. A set event in the same cycle as the clearing write wins.
- R7: Bit 13 reads `dl_active` live when `DLA_CAP` = 1 and reads 0 when `DLA_CAP` = 0.
- R8: Bit 12 reads the parameter `SLOT_CLK`: 1 means the connector reference clock is used, and 0 means an independent clock.
- R9: Bit 11 reads 1 while `train_cfg_rec` = 1. It also reads 1 from the edge after a `retrain_req` until training is seen to begin. It is cleared by link down.
- R10: Bits 3:0 show `link_speed` as registered one cycle earlier and reset to 1. Bits 10:4 read 0. Writes never change bits 13:0.
- R11: `rd_data` is 0 whenever `rd_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request; enables `rd_data` |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data; 1 in bit 15 or 14 clears that bit |
| rd_data | output | 16 | Register value while `rd_en` is high, else 0 |
| train_cfg_rec | input | 1 | Training machine is in configuration or recovery |
| retrain_req | input | 1 | Pulse: software wrote 1 to the retrain-link control |
| bw_chg | input | 1 | Pulse: link speed or width changed |
| bw_auto | input | 1 | Qualifies `bw_chg`: 1 autonomous, 0 reliability or unmarked |
| link_down | input | 1 | Link is in the link-down state |
| dl_active | input | 1 | Data link control is in its active state |
| link_speed | input | 4 | Current link speed code |

## Verification
The bench builds two copies side by side on the same stimulus. One uses the default parameters (`DLA_CAP` = 1, `SLOT_CLK` = 1). The other uses `DLA_CAP` = 0 and `SLOT_CLK` = 0, which brings both values of the hardwired clock bit within reach, and also the forced-zero active bit while `dl_active` toggles. Only that pairing can show that bits 13 and 12 follow the parameters rather than constants. The same sequences cover retrain requests that arrive during training, link-down between request and completion, and set-versus-clear collisions in both parameter sets.

// File: rtl/link_status_reg.sv
module link_status_reg #(
  parameter bit DLA_CAP  = 1'b1,
  parameter bit SLOT_CLK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        train_cfg_rec,
  input  logic        retrain_req,
  input  logic        bw_chg,
  input  logic        bw_auto,
  input  logic        link_down,
  input  logic        dl_active,
  input  logic [3:0]  link_speed
);
  localparam int ZERO_W = 7;

  logic       auto_q, recov_q, pend_q, wait_q, cfg_prev_q;
  logic [3:0] spd_q;

  wire up       = !link_down;
  wire done     = pend_q & cfg_prev_q & !train_cfg_rec & up;
  wire auto_set = up & bw_chg & bw_auto;
  wire recov_set = up & ((bw_chg & !bw_auto) | done);
  wire clr_auto  = wr_en & wr_data[15];
  wire clr_recov = wr_en & wr_data[14];

  wire [15:0] value = {auto_q, recov_q, dl_active & DLA_CAP, SLOT_CLK,
                       train_cfg_rec | wait_q, {ZERO_W{1'b0}}, spd_q};

  assign rd_data = rd_en ? value : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_q     <= 1'b0;
      recov_q    <= 1'b0;
      pend_q     <= 1'b0;
      wait_q     <= 1'b0;
      cfg_prev_q <= 1'b0;
      spd_q      <= 4'd1;
    end else begin
      auto_q     <= auto_set  | (auto_q  & !clr_auto);
      recov_q    <= recov_set | (recov_q & !clr_recov);
      cfg_prev_q <= train_cfg_rec;
      spd_q      <= link_speed;
      if (!up)              pend_q <= 1'b0;
      else if (retrain_req) pend_q <= 1'b1;
      else if (done)        pend_q <= 1'b0;
      if (!up)                wait_q <= 1'b0;
      else if (retrain_req)   wait_q <= 1'b1;
      else if (train_cfg_rec) wait_q <= 1'b0;
    end
  end

  a_r2_auto_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bw_chg && bw_auto && !link_down |=> auto_q);
  a_r3_unmarked_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bw_chg && !bw_auto && !link_down |=> recov_q);
  a_r4_retrain_done: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && $fell(train_cfg_rec) && !link_down |=> recov_q);
  a_r5_down_keeps_auto: assert property (@(posedge clk) disable iff (!rst_n)
    link_down && !auto_q |=> !auto_q);
  a_r5_down_keeps_recov: assert property (@(posedge clk) disable iff (!rst_n)
    link_down && !recov_q |=> !recov_q);
  a_r6_clear_auto: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[15] && !bw_chg |=> !auto_q);
  a_r9_req_trains: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req && !link_down |=> value[11]);
  a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 16'h0000);
endmodule

// File: tb/sim_link_status_reg.sv
module sim_link_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 1'b1, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic train_cfg_rec = 0, retrain_req = 0, bw_chg = 0, bw_auto = 0;
  logic link_down = 0, dl_active = 0;
  logic [3:0] link_speed = 4'd1;
  logic [15:0] rd0, rd1;
  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { logic [15:0] e0; logic [15:0] e1; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  link_status_reg u0 (.clk, .rst_n, .rd_en, .wr_en, .wr_data, .rd_data(rd0),
    .train_cfg_rec, .retrain_req, .bw_chg, .bw_auto, .link_down, .dl_active, .link_speed);
  link_status_reg #(.DLA_CAP(1'b0), .SLOT_CLK(1'b0)) u1 (.clk, .rst_n, .rd_en, .wr_en,
    .wr_data, .rd_data(rd1), .train_cfg_rec, .retrain_req, .bw_chg, .bw_auto,
    .link_down, .dl_active, .link_speed);

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd0 !== it.e0 || rd1 !== it.e1) begin
        fails++;
        $display("FAIL %s: u0=%h exp %h, u1=%h exp %h", it.tag, rd0, it.e0, rd1, it.e1);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // default-parameter expectation; the second copy has bits 13:12 forced low
  task automatic expect_val(input logic [15:0] e, input string tag);
    item_t it;
    it.e0 = e; it.e1 = e & 16'hCFFF; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic expect_pair(input logic [15:0] e0, input logic [15:0] e1, input string tag);
    item_t it;
    it.e0 = e0; it.e1 = e1; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic bw(input logic aut);
    bw_chg = 1; bw_auto = aut; cyc(); bw_chg = 0; bw_auto = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = '0;
  endtask

  task automatic req();
    retrain_req = 1; cyc(); retrain_req = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    expect_pair(16'h1001, 16'h0001, "R1 reset value");
    link_speed = 4'd3; cyc();
    expect_val(16'h1003, "R10 speed field");
    link_speed = 4'd1; cyc();
    bw(1); expect_val(16'h9001, "R2 autonomous change");
    wr(16'h0000); expect_val(16'h9001, "R6 write zero keeps");
    wr(16'hFFFF); expect_val(16'h1001, "R6 R10 clear and RO ignored");
    bw(0); expect_val(16'h5001, "R3 unmarked change");
    wr(16'h4000); expect_val(16'h1001, "R6 clear bit14");
    bw_chg = 1; bw_auto = 1; wr_en = 1; wr_data = 16'h8000; cyc();
    bw_chg = 0; bw_auto = 0; wr_en = 0; wr_data = '0;
    expect_val(16'h9001, "R6 set wins over clear");
    wr(16'h8000); cyc();
    link_down = 1; bw(1); bw(0); link_down = 0; cyc();
    expect_val(16'h1001, "R5 changes ignored while down");
    req(); expect_val(16'h1801, "R9 request before training");
    train_cfg_rec = 1; cyc(); cyc();
    expect_val(16'h1801, "R9 training level");
    train_cfg_rec = 0; cyc();
    expect_val(16'h5001, "R4 retrain completion");
    wr(16'h4000);
    train_cfg_rec = 1; cyc(); req(); cyc();
    train_cfg_rec = 0; cyc();
    expect_val(16'h5001, "R4 request during training");
    wr(16'h4000);
    train_cfg_rec = 1; cyc(); cyc(); train_cfg_rec = 0; cyc();
    expect_val(16'h1001, "R4 unrequested exit");
    req(); train_cfg_rec = 1; cyc(); link_down = 1; cyc(); link_down = 0;
    train_cfg_rec = 0; cyc(); cyc();
    expect_val(16'h1001, "R5 pending retrain discarded");
    req(); link_down = 1; cyc(); link_down = 0; cyc();
    expect_val(16'h1001, "R9 link down clears wait");
    dl_active = 1; #1;
    expect_pair(16'h3001, 16'h0001, "R7 R8 active bit and clock bit");
    dl_active = 0; rd_en = 0; #1;
    expect_pair(16'h0000, 16'h0000, "R11 idle read");
    rd_en = 1; cyc(); cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule